// File: doc/BRIEF.md
# Debug Port Enable and Reset Controller

This block decides whether five shared pins serve the application port or an external debug probe. It holds a single debug-enable bit whose value after reset depends on the reset source. A board-level reset from the external reset pin sets the bit, so the probe owns the pins from the first instruction. A power-on or clock-monitor reset clears the bit, so the pins stay with the application until software sets it. Software reads and writes the bit through a small register port. The pin multiplexers follow the bit directly.

When the bit is set, a rising edge on the debug reset pin starts a controller-wide reset request. The request lasts a fixed number of clocks and leaves the enable bit as it was, so the probe stays attached through the reset it caused. While the bit is clear, the debug reset pin has no effect. The block also supplies the boot address. A mask-ROM build uses address zero. A flash build passes through a configurable vector.

Top module: `dbg_port_ctrl`

## Requirements
- R1: After a power-on reset (`por_n` low, then released), `cfg_rdata` reads 0 and every bit of `pin_sel_dbg` is 0.
- R2: After an external reset (`ext_rst_n` low, then released) with `por_n` high, `cfg_rdata` reads 1, every bit of `pin_sel_dbg` is 1 and every bit of `pad_oe` is 0.
- R3: When `cfg_wr` is 1 at a rising clock edge, `cfg_rdata` takes the value of `cfg_wdata` from that same edge.
- R4: Per pin, `pin_sel_dbg` equals the enable bit. When it is 1, `pad_do` and `pad_oe` are 0. When it is 0, they equal `app_do` and `app_oe`. The multiplexers switch on the same edge as the bit.
- R5: With the bit set, a 0-to-1 change on `dbg_rst_pin` makes `sys_rst_req` go high on the third rising edge after the change and stay high for exactly HOLD_CYCLES (16) clocks.
- R6: While the bit is 0, a rising `dbg_rst_pin` never raises `sys_rst_req`.
- R7: A debugger-triggered reset request does not change the enable bit.
- R8: A new rising edge of `dbg_rst_pin` during an active request restarts the count, so the request ends HOLD_CYCLES clocks after the later detection.
- R9: With IS_FLASH=1, `boot_vec` equals `cfg_vec`.
- R10: With IS_FLASH=0, `boot_vec` is all zeros.
- R11: When `por_n` and `ext_rst_n` are both low, the power-on value wins and the bit reads 0.
- R12: While either reset input is low, `sys_rst_req` is 0, even if a request was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / clock-monitor reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | Write data for the enable bit |
| cfg_rdata | output | 1 | Current enable bit |
| dbg_rst_pin | input | 1 | Debug reset pin from the probe, asynchronous |
| app_do | input | NUM_PINS | Application data for the shared pins |
| app_oe | input | NUM_PINS | Application output enables for the shared pins |
| pin_sel_dbg | output | NUM_PINS | Per-pin owner select, 1 = debug |
| pad_do | output | NUM_PINS | Pad data after the multiplexer |
| pad_oe | output | NUM_PINS | Pad output enable after the multiplexer |
| sys_rst_req | output | 1 | Controller-wide reset request |
| cfg_vec | input | VEC_W | Configured boot vector (flash build) |
| boot_vec | output | VEC_W | Reset vector presented to the core |

## Verification
Two functions can fall in the same cycle: a software write that clears the enable bit, and a debug reset edge that is being detected. A third case is an external reset that arrives while a reset request is still counting. The bench produces both cases with directed sequences. It clears the bit and then drives the pin, which must give no request. It asserts the external reset in the middle of a hold, which must drop the request at once and leave the bit at 1. Between these directed cases, random writes and random pin patterns are checked every cycle against a bench model of the bit and the multiplexers.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned DPC_DEF_PINS = 5;
  localparam int unsigned DPC_DEF_HOLD = 16;

  typedef enum logic {
    OWNER_APP = 1'b0,
    OWNER_DBG = 1'b1
  } pin_owner_e;
endpackage

// File: rtl/dpc_rst_sync.sv
module dpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpc_dbg_reset_gen.sv
module dpc_dbg_reset_gen #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic arm,
  output logic req
);
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   cnt_en;
  logic                   rise;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_async};
    prev_d = sync_q[SYNC_STAGES-1];
    rise   = sync_q[SYNC_STAGES-1] & ~prev_q;
    cnt_en = (rise & arm) | (cnt_q != '0);
    if (rise && arm) cnt_d = HOLD_LD;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign req = (cnt_q != '0);
endmodule

// File: rtl/dpc_pin_mux.sv
module dpc_pin_mux
  import dpc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 5
) (
  input  pin_owner_e          owner,
  input  logic [NUM_PINS-1:0] app_do,
  input  logic [NUM_PINS-1:0] app_oe,
  output logic [NUM_PINS-1:0] sel_dbg,
  output logic [NUM_PINS-1:0] pad_do,
  output logic [NUM_PINS-1:0] pad_oe
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_comb begin
      sel_dbg[i] = (owner == OWNER_DBG);
      pad_do[i]  = (owner == OWNER_DBG) ? 1'b0 : app_do[i];
      pad_oe[i]  = (owner == OWNER_DBG) ? 1'b0 : app_oe[i];
    end
  end
endmodule

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
  import dpc_pkg::*;
#(
  parameter int unsigned NUM_PINS    = DPC_DEF_PINS,
  parameter int unsigned HOLD_CYCLES = DPC_DEF_HOLD,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VEC_W       = 32,
  parameter bit          IS_FLASH    = 1'b1
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                ext_rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_wdata,
  output logic                cfg_rdata,
  input  logic                dbg_rst_pin,
  input  logic [NUM_PINS-1:0] app_do,
  input  logic [NUM_PINS-1:0] app_oe,
  output logic [NUM_PINS-1:0] pin_sel_dbg,
  output logic [NUM_PINS-1:0] pad_do,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                sys_rst_req,
  input  logic [VEC_W-1:0]    cfg_vec,
  output logic [VEC_W-1:0]    boot_vec
);
  logic       por_sync_n;
  logic       ext_sync_n;
  logic       rst_all_n;
  logic       en_q, en_d, en_ld;
  pin_owner_e owner;

  dpc_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_sync_n)
  );
  dpc_rst_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .arst_n(ext_rst_n), .srst_n(ext_sync_n)
  );
  assign rst_all_n = por_sync_n & ext_sync_n;

  // Enable bit: power-on clears it, external reset sets it; power-on wins.
  always_comb begin
    en_ld = cfg_wr;
    en_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge por_sync_n or negedge ext_sync_n) begin
    if (!por_sync_n)      en_q <= 1'b0;
    else if (!ext_sync_n) en_q <= 1'b1;
    else if (en_ld)       en_q <= en_d;
  end

  assign cfg_rdata = en_q;
  assign owner     = en_q ? OWNER_DBG : OWNER_APP;

  dpc_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
    .owner(owner), .app_do(app_do), .app_oe(app_oe),
    .sel_dbg(pin_sel_dbg), .pad_do(pad_do), .pad_oe(pad_oe)
  );

  dpc_dbg_reset_gen #(
    .SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_rgen (
    .clk(clk), .rst_n(rst_all_n), .pin_async(dbg_rst_pin),
    .arm(en_q), .req(sys_rst_req)
  );

  if (IS_FLASH) begin : g_flash_vec
    assign boot_vec = cfg_vec;
  end else begin : g_rom_vec
    assign boot_vec = '0;
  end
endmodule

// File: rtl/dbg_port_ctrl_chk.sv
module dbg_port_ctrl_chk #(
  parameter int unsigned NUM_PINS    = 5,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic                clk,
  input logic                rst_all_n,
  input logic                por_sync_n,
  input logic                ext_sync_n,
  input logic                cfg_wr,
  input logic                cfg_wdata,
  input logic                cfg_rdata,
  input logic [NUM_PINS-1:0] pin_sel_dbg,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                sys_rst_req
);
  localparam int unsigned RUN_W = $clog2(HOLD_CYCLES + 2) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n)       run_q <= '0;
    else if (!sys_rst_req) run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  p_por_clear_r1: assert property (@(posedge clk) !por_sync_n |-> !cfg_rdata);
  p_ext_set_r2: assert property (@(posedge clk) (por_sync_n && !ext_sync_n) |-> cfg_rdata);
  p_write_r3: assert property (@(posedge clk) disable iff (!rst_all_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));
  p_owner_r4: assert property (@(posedge clk) disable iff (!rst_all_n)
    (pin_sel_dbg == {NUM_PINS{cfg_rdata}}) && ((pin_sel_dbg & pad_oe) == '0));
  p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_all_n)
    $fell(sys_rst_req) |-> (run_q >= RUN_W'(HOLD_CYCLES)));
  p_armed_only_r6: assert property (@(posedge clk) disable iff (!rst_all_n)
    $rose(sys_rst_req) |-> $past(cfg_rdata));
  p_bit_kept_r7: assert property (@(posedge clk) disable iff (!rst_all_n)
    (sys_rst_req && !cfg_wr) |=> $stable(cfg_rdata));
  p_quiet_in_reset_r12: assert property (@(posedge clk) !rst_all_n |-> !sys_rst_req);
endmodule

bind dbg_port_ctrl dbg_port_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk(clk), .rst_all_n(rst_all_n), .por_sync_n(por_sync_n),
  .ext_sync_n(ext_sync_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .pin_sel_dbg(pin_sel_dbg), .pad_oe(pad_oe),
  .sys_rst_req(sys_rst_req)
);

// File: tb/sim_dbg_port_ctrl.sv
module sim_dbg_port_ctrl;
  localparam int NP   = 5;
  localparam int HOLD = 16;

  logic          clk = 1'b0;
  logic          por_n = 1'b1, ext_rst_n = 1'b1;
  logic          cfg_wr = 1'b0, cfg_wdata = 1'b0;
  logic          dbg_rst_pin = 1'b0;
  logic [NP-1:0] app_do = '0, app_oe = '0;
  logic [31:0]   cfg_vec = 32'h0000_1000;
  logic          cfg_rdata, sys_rst_req, cfg_rdata_b, sys_rst_req_b;
  logic [NP-1:0] pin_sel_dbg, pad_do, pad_oe, sel_b, do_b, oe_b;
  logic [31:0]   boot_vec, boot_vec_b;

  int n_chk = 0, n_fail = 0;
  bit model_en;

  always #10 clk = ~clk;

  dbg_port_ctrl #(.IS_FLASH(1'b1)) u0 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dbg_rst_pin(dbg_rst_pin),
    .app_do(app_do), .app_oe(app_oe), .pin_sel_dbg(pin_sel_dbg),
    .pad_do(pad_do), .pad_oe(pad_oe), .sys_rst_req(sys_rst_req),
    .cfg_vec(cfg_vec), .boot_vec(boot_vec)
  );

  dbg_port_ctrl #(.IS_FLASH(1'b0)) u1 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_b), .dbg_rst_pin(dbg_rst_pin),
    .app_do(app_do), .app_oe(app_oe), .pin_sel_dbg(sel_b),
    .pad_do(do_b), .pad_oe(oe_b), .sys_rst_req(sys_rst_req_b),
    .cfg_vec(cfg_vec), .boot_vec(boot_vec_b)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] exp_pad(input bit en, input logic [NP-1:0] v);
    return en ? '0 : v;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_bit(input bit v);
    cfg_wr = 1'b1; cfg_wdata = v;
    tick();
    cfg_wr = 1'b0;
    model_en = v;
  endtask

  // Raise the pin now, return number of quiet cycles and high cycles seen.
  task automatic measure(output int lead, output int high, input int gap);
    lead = 0; high = 0;
    dbg_rst_pin = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (gap > 0 && i == 2) dbg_rst_pin = 1'b0;
      if (gap > 0 && i == gap - 1) dbg_rst_pin = 1'b1;
      if (sys_rst_req) high++;
      else if (high == 0) lead++;
    end
    dbg_rst_pin = 1'b0;
    repeat (4) tick();
  endtask

  initial begin
    int lead, high;
    void'($urandom(32'h5eed_0042));
    #1;
    por_n = 1'b0; ext_rst_n = 1'b0;
    repeat (3) tick();
    check(cfg_rdata == 1'b0, "R11 bit with both resets", cfg_rdata, 0);
    check(sys_rst_req == 1'b0, "R12 request in reset", sys_rst_req, 0);
    por_n = 1'b1; ext_rst_n = 1'b1;
    repeat (3) tick();
    check(cfg_rdata == 1'b0, "R1 bit after power-on", cfg_rdata, 0);
    check(pin_sel_dbg == '0, "R1 pin select after power-on", pin_sel_dbg, 0);

    ext_rst_n = 1'b0;
    repeat (2) tick();
    ext_rst_n = 1'b1;
    repeat (3) tick();
    model_en = 1'b1;
    check(cfg_rdata == 1'b1, "R2 bit after external reset", cfg_rdata, 1);
    check(pin_sel_dbg == '1, "R2 pin select after external reset", pin_sel_dbg, '1);
    app_oe = '1;
    #1;
    check(pad_oe == '0, "R2 pads released to debug", pad_oe, 0);

    // Random writes and pin traffic.
    for (int it = 0; it < 300; it++) begin
      bit w, d;
      w = $urandom_range(0, 1);
      d = $urandom_range(0, 1);
      app_do  = NP'($urandom);
      app_oe  = NP'($urandom);
      cfg_vec = $urandom;
      cfg_wr = w; cfg_wdata = d;
      tick();
      cfg_wr = 1'b0;
      if (w) model_en = d;
      check(cfg_rdata == model_en, "R3 read-back", cfg_rdata, model_en);
      check(pin_sel_dbg == {NP{model_en}}, "R4 select", pin_sel_dbg, {NP{model_en}});
      check(pad_do == exp_pad(model_en, app_do), "R4 pad data", pad_do,
            exp_pad(model_en, app_do));
      check(pad_oe == exp_pad(model_en, app_oe), "R4 pad enable", pad_oe,
            exp_pad(model_en, app_oe));
      check(boot_vec == cfg_vec, "R9 flash vector", boot_vec, cfg_vec);
      check(boot_vec_b == '0, "R10 rom vector", boot_vec_b, 0);
    end

    // Debugger reset while enabled.
    write_bit(1'b1);
    measure(lead, high, 0);
    check(lead == 2, "R5 request start", lead, 2);
    check(high == HOLD, "R5 request length", high, HOLD);
    check(cfg_rdata == 1'b1, "R7 bit kept after request", cfg_rdata, 1);

    // Retrigger during hold: second rise 6 cycles after the first.
    measure(lead, high, 6);
    check(high == 6 + HOLD, "R8 restarted request length", high, 6 + HOLD);

    // Disabled: pin ignored.
    write_bit(1'b0);
    measure(lead, high, 0);
    check(high == 0, "R6 no request while disabled", high, 0);
    check(cfg_rdata == 1'b0, "R6 bit unchanged", cfg_rdata, 0);

    // External reset in the middle of a hold.
    write_bit(1'b1);
    dbg_rst_pin = 1'b1;
    repeat (8) tick();
    check(sys_rst_req == 1'b1, "R5 request active mid-hold", sys_rst_req, 1);
    ext_rst_n = 1'b0;
    #2;
    check(sys_rst_req == 1'b0, "R12 request dropped by reset", sys_rst_req, 0);
    tick();
    ext_rst_n = 1'b1;
    dbg_rst_pin = 1'b0;
    repeat (3) tick();
    check(cfg_rdata == 1'b1, "R2 bit set after reset in hold", cfg_rdata, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule